// File: doc/BRIEF.md
# Floating-Point to Signed Word Converter

This unit turns one IEEE binary32 or binary64 operand into a signed 32-bit integer. It sits behind the floating-point register file of a processor pipeline. Each request carries the operand, a precision select, a conversion opcode and the rounding mode currently held in the control register.

One opcode rounds with that live mode. The other four each apply a fixed rounding direction for that single conversion only. The unit keeps no rounding state of its own, so the mode it is given is the same after the conversion as before.

Out-of-range results, NaN inputs and infinite inputs saturate to the largest positive word and raise an invalid flag. Any rounding that loses information raises an inexact flag. Requests enter and results leave through valid/ready handshakes, with one register stage between them.

Top module: `f2i_cvt`

## Requirements
- R1: `in_ready_o` is high whenever the output register is empty or `out_ready_i` is high. An accepted request produces its result with `out_valid_o` on the cycle after acceptance. While `out_valid_o` is high and `out_ready_i` is low, the result and both flags hold steady.
- R2: Opcode 0 (and the unused codes 5 to 7) rounds with `rmode_i`. The encoding of `rmode_i` is: 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R3: Opcode 1 rounds to nearest with ties to even, whatever `rmode_i` holds.
- R4: Opcode 2 rounds toward zero, whatever `rmode_i` holds.
- R5: Opcode 3 rounds toward +infinity, whatever `rmode_i` holds.
- R6: Opcode 4 rounds toward -infinity, whatever `rmode_i` holds.
- R7: With `dbl_i`=1, `operand_i[63:0]` is read as binary64. With `dbl_i`=0, `operand_i[31:0]` is read as binary32 and `operand_i[63:32]` has no effect on the result.
- R8: These inputs give result 0x7FFFFFFF, invalid=1 and inexact=0: a NaN, an infinity, or a rounded value above 2147483647 or below -2147483648. A rounded value of exactly -2147483648 is valid.
- R9: For in-range results, inexact is 1 exactly when the rounded integer differs from the operand's value. Invalid is then 0.
- R10: A subnormal input gives 0, or +1/-1 under a directed mode that rounds away from zero, and always sets inexact. Signed zeros give 0 with no flag.
- R11: A fixed-direction opcode leaves no trace. A following opcode-0 request rounds with its own `rmode_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request can be taken |
| operand_i | input | 64 | Floating-point operand; binary32 in bits 31:0 |
| dbl_i | input | 1 | 1 = binary64, 0 = binary32 |
| op_i | input | 3 | Conversion opcode |
| rmode_i | input | 2 | Live rounding mode |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes result |
| result_o | output | 32 | Signed integer result |
| inexact_o | output | 1 | Rounding lost information |
| invalid_o | output | 1 | NaN, infinity or overflow |

## Verification
The bench builds the unit with its default formats: a binary64 source with a 53-bit significand, a binary32 source, and a 32-bit result. This places the exponent-31 boundary within reach from both precisions, so the bench can hit the exact -2^31 case, overflow caused only by rounding up, and ties at the largest magnitudes. The bench also covers subnormals of both widths, half-way ties in every mode, and back-to-back requests under consumer stalls.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
package f2i_pkg;
  localparam int DP_EXP_W = 11;
  localparam int DP_MAN_W = 52;
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int SIG_W    = DP_MAN_W + 1;
  localparam int EXP_W    = DP_EXP_W + 2;
  localparam int INT_W    = 32;

  typedef enum logic [2:0] {
    OP_CVT  = 3'd0,
    OP_RND  = 3'd1,
    OP_TRC  = 3'd2,
    OP_CEIL = 3'd3,
    OP_FLR  = 3'd4
  } cvt_op_e;

  typedef enum logic [1:0] {
    RM_NE = 2'd0,
    RM_RZ = 2'd1,
    RM_UP = 2'd2,
    RM_DN = 2'd3
  } rmode_e;

  function automatic rmode_e pick_mode(logic [2:0] op, logic [1:0] live);
    case (op)
      OP_RND:  return RM_NE;
      OP_TRC:  return RM_RZ;
      OP_CEIL: return RM_UP;
      OP_FLR:  return RM_DN;
      default: return rmode_e'(live);
    endcase
  endfunction
endpackage

// File: rtl/f2i_unpack.sv
`timescale 1ns/1ps
module f2i_unpack
  import f2i_pkg::*;
#(
  parameter int DE_W = DP_EXP_W,
  parameter int DM_W = DP_MAN_W,
  parameter int SE_W = SP_EXP_W,
  parameter int SM_W = SP_MAN_W,
  parameter int E_W  = EXP_W
) (
  input  logic [DE_W+DM_W:0]     operand_i,
  input  logic                   dbl_i,
  output logic                   sign_o,
  output logic signed [E_W-1:0]  exp_o,
  output logic [DM_W:0]          sig_o,
  output logic                   special_o,
  output logic                   zero_o,
  output logic                   den_o
);
  localparam int DBIAS = (1 << (DE_W - 1)) - 1;
  localparam int SBIAS = (1 << (SE_W - 1)) - 1;
  localparam int SPAD  = DM_W - SM_W;

  logic [DE_W-1:0] d_exp;
  logic [DM_W-1:0] d_man;
  logic [SE_W-1:0] s_exp;
  logic [SM_W-1:0] s_man;

  assign d_exp = operand_i[DE_W+DM_W-1:DM_W];
  assign d_man = operand_i[DM_W-1:0];
  assign s_exp = operand_i[SE_W+SM_W-1:SM_W];
  assign s_man = operand_i[SM_W-1:0];

  always_comb begin
    if (dbl_i) begin
      sign_o    = operand_i[DE_W+DM_W];
      special_o = &d_exp;
      zero_o    = (d_exp == '0) && (d_man == '0);
      den_o     = (d_exp == '0) && (d_man != '0);
      sig_o     = {d_exp != '0, d_man};
      exp_o     = (d_exp == '0) ? E_W'(1 - DBIAS)
                                : E_W'($signed({2'b00, d_exp}) - DBIAS);
    end else begin
      sign_o    = operand_i[SE_W+SM_W];
      special_o = &s_exp;
      zero_o    = (s_exp == '0) && (s_man == '0);
      den_o     = (s_exp == '0) && (s_man != '0);
      sig_o     = {s_exp != '0, s_man, {SPAD{1'b0}}};
      // subnormal: any exponent below -1 gives sticky-only path
      exp_o     = (s_exp == '0) ? E_W'(1 - DBIAS)
                                : E_W'($signed({{(E_W-SE_W){1'b0}}, s_exp}) - SBIAS);
    end
  end
endmodule

// File: rtl/f2i_round.sv
`timescale 1ns/1ps
module f2i_round
  import f2i_pkg::*;
#(
  parameter int S_W = SIG_W,
  parameter int E_W = EXP_W,
  parameter int I_W = INT_W
) (
  input  logic                  sign_i,
  input  logic signed [E_W-1:0] exp_i,
  input  logic [S_W-1:0]        sig_i,
  input  logic                  special_i,
  input  rmode_e                mode_i,
  output logic [I_W-1:0]        result_o,
  output logic                  inexact_o,
  output logic                  invalid_o
);
  localparam int X_W = S_W + I_W;
  localparam int SH_W = $clog2(I_W);
  localparam logic [I_W:0] POS_MAX = {2'b00, {(I_W-1){1'b1}}};
  localparam logic [I_W:0] NEG_MAX = {2'b01, {(I_W-1){1'b0}}};

  logic [X_W-1:0] shifted;
  logic [I_W:0]   int_part, mag;
  logic           rnd_bit, sticky, inc, too_big, ovf;

  always_comb begin
    shifted  = {{I_W{1'b0}}, sig_i} << exp_i[SH_W-1:0];
    too_big  = exp_i > E_W'(I_W - 1);
    if (exp_i < 0) begin
      int_part = '0;
      rnd_bit  = (exp_i == -1) ? sig_i[S_W-1] : 1'b0;
      sticky   = (exp_i == -1) ? |sig_i[S_W-2:0] : |sig_i;
    end else begin
      int_part = shifted[X_W-1:S_W-1];
      rnd_bit  = shifted[S_W-2];
      sticky   = |shifted[S_W-3:0];
    end
    case (mode_i)
      RM_NE:   inc = rnd_bit & (sticky | int_part[0]);
      RM_RZ:   inc = 1'b0;
      RM_UP:   inc = (rnd_bit | sticky) & ~sign_i;
      default: inc = (rnd_bit | sticky) & sign_i;
    endcase
    mag = int_part + {{I_W{1'b0}}, inc};
    ovf = special_i | too_big | (sign_i ? (mag > NEG_MAX) : (mag > POS_MAX));
    if (ovf) begin
      result_o  = POS_MAX[I_W-1:0];
      inexact_o = 1'b0;
      invalid_o = 1'b1;
    end else begin
      result_o  = sign_i ? (~mag[I_W-1:0] + 1'b1) : mag[I_W-1:0];
      inexact_o = rnd_bit | sticky;
      invalid_o = 1'b0;
    end
  end
endmodule

// File: rtl/f2i_cvt.sv
`timescale 1ns/1ps
module f2i_cvt
  import f2i_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  output logic                       in_ready_o,
  input  logic [DP_EXP_W+DP_MAN_W:0] operand_i,
  input  logic                       dbl_i,
  input  logic [2:0]                 op_i,
  input  logic [1:0]                 rmode_i,
  output logic                       out_valid_o,
  input  logic                       out_ready_i,
  output logic [INT_W-1:0]           result_o,
  output logic                       inexact_o,
  output logic                       invalid_o
);
  logic                    u_sign, u_special, u_zero, u_den;
  logic signed [EXP_W-1:0] u_exp;
  logic [SIG_W-1:0]        u_sig;
  rmode_e                  eff_mode;
  logic [INT_W-1:0]        r_res;
  logic                    r_inx, r_inv, accept;

  f2i_unpack unpack_i (
    .operand_i (operand_i),
    .dbl_i     (dbl_i),
    .sign_o    (u_sign),
    .exp_o     (u_exp),
    .sig_o     (u_sig),
    .special_o (u_special),
    .zero_o    (u_zero),
    .den_o     (u_den)
  );

  // override is combinational only: no mode state is kept
  assign eff_mode = pick_mode(op_i, rmode_i);

  f2i_round round_i (
    .sign_i    (u_sign),
    .exp_i     (u_exp),
    .sig_i     (u_sig),
    .special_i (u_special),
    .mode_i    (eff_mode),
    .result_o  (r_res),
    .inexact_o (r_inx),
    .invalid_o (r_inv)
  );

  assign in_ready_o = ~out_valid_o | out_ready_i;
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      inexact_o   <= 1'b0;
      invalid_o   <= 1'b0;
    end else begin
      if (accept) begin
        out_valid_o <= 1'b1;
        result_o    <= r_res;
        inexact_o   <= r_inx;
        invalid_o   <= r_inv;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end

  assert_hold_on_stall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o) && $stable(invalid_o));
  assert_accept_gives_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);
  assert_special_invalid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && u_special |=> invalid_o && !inexact_o);
  assert_positive_nonneg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !u_sign |=> !result_o[INT_W-1]);
  assert_zero_exact_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && u_zero |=> result_o == '0 && !inexact_o && !invalid_o);
  assert_denormal_inexact_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && u_den |=> inexact_o);
endmodule

// File: tb/f2i_cvt_tb_top.sv
`timescale 1ns/1ps
module f2i_cvt_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [63:0] operand_i = '0;
  logic        dbl_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  rmode_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] result_o;
  logic        inexact_o, invalid_o;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;
  logic [31:0] exp_res_q[$];
  logic        exp_inv_q[$];
  logic        exp_inx_q[$];
  string       tag_q[$];
  logic        prev_stall = 0;
  logic [31:0] prev_res = '0;

  always #2 clk_i = ~clk_i;

  f2i_cvt dut_i (.*);

  function automatic void ref_conv(input logic [2:0] op, input logic dbl, input logic [1:0] rm,
                                   input logic [63:0] b, output logic [31:0] r,
                                   output logic inv, output logic inx);
    int md, e;
    real v, f, q, d;
    logic spec;
    md = (op == 1) ? 0 : (op == 2) ? 1 : (op == 3) ? 2 : (op == 4) ? 3 : int'(rm);
    if (dbl) begin
      spec = (b[62:52] == 11'h7FF);
      v = $bitstoreal(b);
    end else begin
      e = int'(b[30:23]);
      spec = (e == 255);
      if (e == 0) v = real'(b[22:0]) * (2.0 ** (-149));
      else v = (8388608.0 + real'(b[22:0])) * (2.0 ** (e - 150));
      if (b[31]) v = -v;
    end
    if (spec) begin
      r = 32'h7FFFFFFF; inv = 1; inx = 0; return;
    end
    f = $floor(v);
    case (md)
      0: begin
        d = v - f;
        if (d > 0.5) q = f + 1.0;
        else if (d < 0.5) q = f;
        else q = ((longint'(f) % 2) == 0) ? f : f + 1.0;
      end
      1: q = (v < 0.0) ? $ceil(v) : f;
      2: q = $ceil(v);
      default: q = f;
    endcase
    if (q > 2147483647.0 || q < -2147483648.0) begin
      r = 32'h7FFFFFFF; inv = 1; inx = 0;
    end else begin
      r = 32'(longint'(q)); inv = 0; inx = (q != v);
    end
  endfunction

  task automatic send(input string tag, input logic [2:0] op, input logic dbl,
                      input logic [1:0] rm, input logic [63:0] b);
    logic [31:0] r;
    logic inv, inx;
    bit took;
    ref_conv(op, dbl, rm, b, r, inv, inx);
    @(negedge clk_i); #1;
    in_valid_i = 1; op_i = op; dbl_i = dbl; rmode_i = rm; operand_i = b;
    took = 0;
    while (!took) begin
      #0.5;
      if (in_ready_o) begin
        took = 1;
        exp_res_q.push_back(r); exp_inv_q.push_back(inv);
        exp_inx_q.push_back(inx); tag_q.push_back(tag);
      end
      @(negedge clk_i); #1;
    end
    in_valid_i = 0;
  endtask

  always @(negedge clk_i) begin
    #1;
    cyc++;
    out_ready_i = (cyc % 5) != 3;
  end

  always @(negedge clk_i) begin
    #2;
    if (rst_ni && !done) begin
      if (prev_stall) begin
        n_checks++;
        if (!out_valid_o || result_o != prev_res) begin
          n_fail++;
          $display("FAIL R1 stall hold: valid=%0b res=%h expected valid=1 res=%h",
                   out_valid_o, result_o, prev_res);
        end
      end
      if (out_valid_o && out_ready_i) begin
        n_checks++;
        if (exp_res_q.size() == 0) begin
          n_fail++;
          $display("FAIL R1 unexpected output res=%h expected none", result_o);
        end else begin
          if (result_o != exp_res_q[0] || invalid_o != exp_inv_q[0] || inexact_o != exp_inx_q[0]) begin
            n_fail++;
            $display("FAIL %s res=%h inv=%0b inx=%0b expected res=%h inv=%0b inx=%0b",
                     tag_q[0], result_o, invalid_o, inexact_o,
                     exp_res_q[0], exp_inv_q[0], exp_inx_q[0]);
          end
          void'(exp_res_q.pop_front()); void'(exp_inv_q.pop_front());
          void'(exp_inx_q.pop_front()); void'(tag_q.pop_front());
        end
      end
      prev_stall = out_valid_o && !out_ready_i;
      prev_res = result_o;
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        n_checks++;
        if (out_valid_o !== 1'b0 || in_ready_o !== 1'b1) begin
          n_fail++;
          $display("FAIL R1 reset: valid=%0b ready=%0b expected 0 1", out_valid_o, in_ready_o);
        end
        #1 rst_ni = 1;
        // R2 live mode
        send("R2 cvt ne 2.5", 0, 1, 0, $realtobits(2.5));
        send("R2 cvt up 2.5", 0, 1, 2, $realtobits(2.5));
        send("R2 cvt dn -2.5", 0, 1, 3, $realtobits(-2.5));
        send("R2 cvt rz -2.7", 0, 1, 1, $realtobits(-2.7));
        send("R2 code7 up", 7, 1, 2, $realtobits(1.25));
        // R3 nearest even override
        send("R3 round 2.5 rm dn", 1, 1, 3, $realtobits(2.5));
        send("R3 round 3.5 rm rz", 1, 1, 1, $realtobits(3.5));
        send("R3 round 0.5", 1, 1, 2, $realtobits(0.5));
        send("R3 round 0.75", 1, 1, 1, $realtobits(0.75));
        send("R3 round sp 1.5", 1, 0, 3, 64'h3FC00000);
        // R4..R6
        send("R4 trunc -2.5", 2, 1, 2, $realtobits(-2.5));
        send("R4 trunc 2^31-0.5", 2, 1, 2, $realtobits(2147483647.5));
        send("R5 ceil 2.5", 3, 1, 3, $realtobits(2.5));
        send("R5 ceil -2.5", 3, 1, 0, $realtobits(-2.5));
        send("R6 floor -2.5", 4, 1, 2, $realtobits(-2.5));
        send("R6 floor sp -7.25", 4, 0, 2, 64'hC0E80000);
        // R11 override leaves no trace
        send("R11 ceil", 3, 1, 0, $realtobits(2.5));
        send("R11 cvt after ceil", 0, 1, 0, $realtobits(2.5));
        send("R11 floor", 4, 1, 1, $realtobits(-3.5));
        send("R11 cvt after floor", 0, 1, 1, $realtobits(-3.5));
        // R7 precision
        send("R7 sp 100", 0, 0, 0, 64'h0000000042C80000);
        send("R7 sp upper ignored", 0, 0, 0, 64'hDEADBEEF42C80000);
        send("R7 sp upper ignored 2", 3, 0, 0, 64'hFFFFFFFF3FC00000);
        send("R7 dp 123456789.25", 0, 1, 0, $realtobits(123456789.25));
        // R8 invalid
        send("R8 dp nan", 0, 1, 0, 64'h7FF8000000000000);
        send("R8 sp inf", 0, 0, 0, 64'h7F800000);
        send("R8 sp -inf", 2, 0, 0, 64'hFF800000);
        send("R8 dp 3e9", 2, 1, 0, $realtobits(3.0e9));
        send("R8 dp -2^31 exact", 0, 1, 0, $realtobits(-2147483648.0));
        send("R8 ceil 2^31-0.5", 3, 1, 0, $realtobits(2147483647.5));
        send("R8 ne -2^31-0.5", 1, 1, 0, $realtobits(-2147483648.5));
        send("R8 floor -2^31-0.5", 4, 1, 0, $realtobits(-2147483648.5));
        send("R8 sp 2^31", 0, 0, 0, 64'h4F000000);
        send("R8 sp -2^31", 0, 0, 0, 64'hCF000000);
        // R9 exactness
        send("R9 exact 7", 0, 1, 2, $realtobits(7.0));
        send("R9 inexact 7.001", 2, 1, 0, $realtobits(7.001));
        // R10 subnormal and zero
        send("R10 dp den ceil", 3, 1, 0, 64'h0000000000000001);
        send("R10 dp -den floor", 4, 1, 0, 64'h8000000000000001);
        send("R10 dp -den trunc", 2, 1, 0, 64'h8000000000000001);
        send("R10 sp den ne", 0, 0, 0, 64'h00000001);
        send("R10 sp den up", 0, 0, 2, 64'h00400000);
        send("R10 zero", 3, 1, 0, 64'h0);
        send("R10 neg zero", 4, 0, 0, 64'h80000000);
        repeat (10) @(negedge clk_i);
        n_checks++;
        if (exp_res_q.size() != 0) begin
          n_fail++;
          $display("FAIL R1 lost results: pending=%0d expected 0", exp_res_q.size());
        end
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_checks++; n_fail++;
        $display("FAIL R1 watchdog expired: got hang expected completion");
      end
    join_any
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule